// File: doc/BRIEF.md
# SDRAM Power-Up Mode-Setting Sequencer

This block brings one SDRAM chip-select area from power-up to a programmed state. After a synchronous reset it waits a programmable number of cycles for the device's power-on settling time. It then waits for a start request. Once the request is accepted, it drives the command pins through this sequence: a precharge of all banks, a fixed run of auto-refresh commands, and a write of the mode register. No-operation cycles of programmable length separate the commands.

The mode register value carries the CAS latency, the write-burst policy and a burst length of one. The block places this value on the external address bus, shifted left by the byte-lane offset that the data bus width implies. A sticky done flag tells the surrounding memory controller when normal traffic may begin. The block does not handle reads, writes, periodic refresh, bank state or the data pins.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and directly after it, the command pins are in deselect (csN, rasN, casN and weN all 1), addr is 0 and done is 0.
- R2: start is ignored during the power-on wait. If start is held high from reset release, the pins stay in deselect until PALL appears after clock edge pwrWait+3 counted from release. A pulse of start inside the wait produces no command.
- R3: When start is sampled high after the wait, PALL is on the pins in the second cycle after that edge, and the first cycle shows deselect.
- R4: Pin encodings {csN,rasN,casN,weN}: all-bank precharge PALL = 0010, auto refresh REF = 0001, mode register set MRS = 0000, no-operation NOP = 0111, deselect = 1111. No other code ever appears.
- R5: Exactly trpSel+1 NOP cycles separate PALL from the first REF.
- R6: Exactly 8 REF commands are issued. Each one is followed by exactly trcSel+1 NOP cycles, and the gap after the eighth REF ends with MRS.
- R7: During MRS, addr equals the mode word shifted left by 1 (busWide=0, 16-bit bus) or by 2 (busWide=1, 32-bit bus). In the mode word, bit 9 is 1 when burstWrite=0 (single write), bits 6:4 hold the CAS latency (2 when casLat3=0, 3 when casLat3=1), and all other bits are 0. The resulting values are 0x440/0x460/0x880/0x8C0 with single write and 0x040/0x060/0x080/0x0C0 with burst write.
- R8: addr is 0 in every cycle that is not an MRS cycle.
- R9: MRS is followed by exactly one NOP. Then done rises with the pins in deselect, and done stays high until reset. A start request while done is high has no effect.
- R10: One sequence contains exactly one PALL and exactly one MRS, and PALL comes before every REF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the mode-setting sequence |
| busWide | input | 1 | 0: 16-bit data bus, 1: 32-bit data bus |
| casLat3 | input | 1 | 0: CAS latency 2, 1: CAS latency 3 |
| burstWrite | input | 1 | 1: burst write, 0: single write |
| trpSel | input | 2 | Precharge-to-refresh idle setting (n gives n+1 cycles) |
| trcSel | input | 2 | Refresh-cycle idle setting (n gives n+1 cycles) |
| pwrWait | input | 16 | Power-on wait length in cycles (0 skips) |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | 13 | External address bus |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
Two events can fall on the same clock edge. The first pair is the end of the power-on wait and a pending start request. The second pair is the expiry of a refresh gap and the refresh count reaching its terminal value, which decides between another REF and the MRS. The bench holds start high from reset release so that the request sits on the edge where the wait ends. It judges the outcome by the exact cycle in which PALL appears. It sweeps every combination of gap setting, bus width, CAS latency and write mode, and compares the whole pin trace cycle by cycle. A ninth REF or an early MRS therefore shows up as a mismatch at a known position.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PALL  = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_MRS   = 4'b0000
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWAIT, ST_ARM, ST_PALL, ST_GAP_RP, ST_REF,
    ST_GAP_RC, ST_MRS, ST_GAP_MRS, ST_DONE
  } state_e;

  typedef struct packed {
    cmd_e cmd;
    logic waitInc;
    logic loadRp;
    logic loadRc;
    logic gapDec;
    logic refInc;
    logic finished;
  } strobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    waitDone,
  input  logic    gapZero,
  input  logic    refAll,
  output strobe_t stb
);

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PWAIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    stb.cmd      = CMD_DESEL;
    stb.waitInc  = 1'b0;
    stb.loadRp   = 1'b0;
    stb.loadRc   = 1'b0;
    stb.gapDec   = 1'b0;
    stb.refInc   = 1'b0;
    stb.finished = 1'b0;
    case (state)
      ST_PWAIT: begin
        if (waitDone) stateNext = ST_ARM;
        else          stb.waitInc = 1'b1;
      end
      ST_ARM: begin
        if (start) stateNext = ST_PALL;
      end
      ST_PALL: begin
        stb.cmd    = CMD_PALL;
        stb.loadRp = 1'b1;
        stateNext  = ST_GAP_RP;
      end
      ST_GAP_RP: begin
        stb.cmd = CMD_NOP;
        if (gapZero) stateNext  = ST_REF;
        else         stb.gapDec = 1'b1;
      end
      ST_REF: begin
        stb.cmd    = CMD_REF;
        stb.loadRc = 1'b1;
        stb.refInc = 1'b1;
        stateNext  = ST_GAP_RC;
      end
      ST_GAP_RC: begin
        stb.cmd = CMD_NOP;
        if (gapZero) stateNext  = refAll ? ST_MRS : ST_REF;
        else         stb.gapDec = 1'b1;
      end
      ST_MRS: begin
        stb.cmd   = CMD_MRS;
        stateNext = ST_GAP_MRS;
      end
      ST_GAP_MRS: begin
        stb.cmd   = CMD_NOP;
        stateNext = ST_DONE;
      end
      ST_DONE: stb.finished = 1'b1;
      default: stateNext = ST_PWAIT;
    endcase
  end

endmodule

// File: rtl/sdram_init_dpath.sv
module sdram_init_dpath
  import sdram_init_pkg::*;
#(
  parameter int WAIT_W    = 16,
  parameter int ADDR_W    = 13,
  parameter int REF_COUNT = 8,
  parameter int GAP_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WAIT_W-1:0] pwrWait,
  input  logic [GAP_W-1:0]  trpSel,
  input  logic [GAP_W-1:0]  trcSel,
  input  logic              busWide,
  input  logic              casLat3,
  input  logic              burstWrite,
  output logic              waitDone,
  output logic              gapZero,
  output logic              refAll,
  output logic [3:0]        cmdPins,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int RC_W   = $clog2(REF_COUNT + 1);
  localparam int MODE_W = 10;

  logic [WAIT_W-1:0] waitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [RC_W-1:0]   refCnt;
  logic [MODE_W-1:0] modeWord;
  logic [ADDR_W-1:0] modeAddr;

  assign waitDone = (waitCnt == pwrWait);
  assign gapZero  = (gapCnt == '0);
  assign refAll   = (refCnt == RC_W'(REF_COUNT));

  // write policy at bit 9, CAS latency in 6:4, burst length code 0 in 2:0
  assign modeWord = {~burstWrite, 2'b00, (casLat3 ? 3'd3 : 3'd2), 1'b0, 3'b000};
  assign modeAddr = busWide ? (ADDR_W'(modeWord) << 2) : (ADDR_W'(modeWord) << 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      gapCnt  <= '0;
      refCnt  <= '0;
      cmdPins <= CMD_DESEL;
      addr    <= '0;
      done    <= 1'b0;
    end else begin
      if (stb.waitInc) waitCnt <= waitCnt + 1'b1;
      if (stb.loadRp)      gapCnt <= trpSel;
      else if (stb.loadRc) gapCnt <= trcSel;
      else if (stb.gapDec) gapCnt <= gapCnt - 1'b1;
      if (stb.refInc) refCnt <= refCnt + 1'b1;
      cmdPins <= stb.cmd;
      addr    <= (stb.cmd == CMD_MRS) ? modeAddr : '0;
      done    <= stb.finished;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int WAIT_W    = 16,
  parameter int ADDR_W    = 13,
  parameter int REF_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              busWide,
  input  logic              casLat3,
  input  logic              burstWrite,
  input  logic [1:0]        trpSel,
  input  logic [1:0]        trcSel,
  input  logic [WAIT_W-1:0] pwrWait,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  strobe_t    stb;
  logic       waitDone, gapZero, refAll;
  logic [3:0] cmdPins;

  sdram_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .waitDone(waitDone), .gapZero(gapZero), .refAll(refAll), .stb(stb)
  );

  sdram_init_dpath #(
    .WAIT_W(WAIT_W), .ADDR_W(ADDR_W), .REF_COUNT(REF_COUNT), .GAP_W(2)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .pwrWait(pwrWait),
    .trpSel(trpSel), .trcSel(trcSel), .busWide(busWide),
    .casLat3(casLat3), .burstWrite(burstWrite),
    .waitDone(waitDone), .gapZero(gapZero), .refAll(refAll),
    .cmdPins(cmdPins), .addr(addr), .done(done)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);

  logic [3:0] pins;
  assign pins = {csN, rasN, casN, weN};

  p_legal_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b1111 || pins == 4'b0111 || pins == 4'b0010 ||
     pins == 4'b0001 || pins == 4'b0000));

  p_addr_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pins != 4'b0000) |-> (addr == '0));

  p_mrs_then_nop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0000) |=> (pins == 4'b0111 && !done));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  p_done_desel_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pins == 4'b1111));

  p_pall_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0010) |=> (pins == 4'b0111));

  p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0001) |=> (pins == 4'b0111));

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .addr(addr), .done(done)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busWide = 1'b0, casLat3 = 1'b0, burstWrite = 1'b0;
  logic [1:0]  trpSel = '0, trcSel = '0;
  logic [15:0] pwrWait = '0;
  logic        csN, rasN, casN, weN, done;
  logic [12:0] addr;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  localparam logic [3:0] P_DESEL = 4'b1111, P_NOP = 4'b0111,
                         P_PALL = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

  always #2 clk = ~clk;

  sdram_init_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busWide(busWide),
    .casLat3(casLat3), .burstWrite(burstWrite), .trpSel(trpSel),
    .trcSel(trcSel), .pwrWait(pwrWait), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .addr(addr), .done(done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expectPins(input logic [3:0] code, input string req);
    logic [3:0] p;
    p = {csN, rasN, casN, weN};
    check(p == code, req, {28'd0, p}, {28'd0, code});
    if (code != P_MRS) check(addr == '0, "R8 addr quiet", {19'd0, addr}, 32'd0);
  endtask

  task automatic runCase(input int idx);
    bit held;
    int w, trp, trc;
    logic [12:0] expAddr;
    logic [9:0] mw;
    held = idx[5] ^ idx[0];
    w    = idx % 4;
    trp  = (idx >> 3) & 3;
    trc  = (idx >> 5) & 3;
    @(negedge clk);
    rstN = 1'b0; start = held;
    busWide = idx[0]; casLat3 = idx[1]; burstWrite = idx[2];
    trpSel = 2'(trp); trcSel = 2'(trc); pwrWait = 16'(w);
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check({csN, rasN, casN, weN, done} == 5'b11110 && addr == '0,
          "R1 reset state", {19'd0, addr, csN, rasN, casN, weN, done}, 32'h1E);
    rstN = 1'b1;
    if (held) begin
      // R2: start held across the end of the power wait
      for (int i = 1; i <= w + 2; i++) begin
        @(negedge clk);
        expectPins(P_DESEL, "R2 held start waits");
      end
      @(negedge clk);
      expectPins(P_PALL, "R2 PALL timing with held start");
      start = 1'b0;
    end else begin
      @(negedge clk);
      if (w >= 1) start = 1'b1;          // sampled inside power wait
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < w + 3; i++) begin
        @(negedge clk);
        expectPins(P_DESEL, "R2 early start ignored");
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      expectPins(P_DESEL, "R3 first cycle after start");
      @(negedge clk);
      expectPins(P_PALL, "R3 PALL after start");
    end
    for (int i = 0; i <= trp; i++) begin
      @(negedge clk);
      expectPins(P_NOP, "R5 precharge gap");
    end
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      expectPins(P_REF, "R6 refresh");
      for (int i = 0; i <= trc; i++) begin
        @(negedge clk);
        expectPins(P_NOP, "R6 refresh gap");
      end
    end
    mw = {~burstWrite, 2'b00, (casLat3 ? 3'd3 : 3'd2), 4'b0000};
    expAddr = busWide ? (13'(mw) << 2) : (13'(mw) << 1);
    @(negedge clk);
    expectPins(P_MRS, "R10 single MRS after eighth REF");
    check(addr == expAddr, "R7 mode word on address", {19'd0, addr}, {19'd0, expAddr});
    @(negedge clk);
    expectPins(P_NOP, "R9 NOP after MRS");
    check(done == 1'b0, "R9 done low during NOP", {31'd0, done}, 32'd0);
    @(negedge clk);
    expectPins(P_DESEL, "R9 deselect when done");
    check(done == 1'b1, "R9 done rises", {31'd0, done}, 32'd1);
    start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expectPins(P_DESEL, "R9 start ignored when done");
      check(done == 1'b1, "R9 done sticky", {31'd0, done}, 32'd1);
    end
    start = 1'b0;
  endtask

  initial begin
    for (int idx = 0; idx < 128; idx++) runCase(idx);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule